// File: doc/BRIEF.md
# Tuning Window Centre Selector

This block chooses a sampling tap after a phase sweep. Each bit of its input map is the pass (1) or fail (0) result of one probe. The map covers two full sweeps of the N taps, so a passing window that runs past the last tap and continues at tap 0 appears as one unbroken run.

After a start strobe the block walks the map one bit per clock and tracks the longest run of consecutive passes, with its first and last index. When the walk ends it reports the middle of that run, folded back into the range 0..N-1. If the longest run is shorter than a minimum length, it reports an error instead. Running the probes and loading the chosen tap into the sampling logic belong to the surrounding controller.

Top module: `tap_window_picker`

## Requirements
- R1: During and straight after reset, done_o, err_o and tap_o are all 0.
- R2: A start_i sampled high while the block is idle is accepted. done_o is then high for exactly one cycle, which begins 2N+1 clock cycles after the accepting edge, where N is the tap_num_i value captured at that edge.
- R3: Only map bits 0 to 2N-1 are scanned, with bit i holding the result of probe i (bit 0 is the LSB). Bits at index 2N and above have no effect. A pass window that wraps from tap N-1 to tap 0 counts as one run.
- R4: A run replaces the best run so far only when it is strictly longer, so on a tie the run with the lower start index is chosen.
- R5: A run still open at bit 2N-1 is compared against the best run in the same way as a run that a 0 bit ends.
- R6: If the longest run has fewer than MIN_RUN (default 3) passes, err_o is 1 and tap_o is 0 at done.
- R7: Otherwise err_o is 0 and tap_o equals ((start + end) / 2) mod N, where start and end are the first and last indices of the chosen run and the division rounds down.
- R8: A start_i that arrives while a scan is in progress (from the accepting edge up to the done cycle) is ignored. It neither restarts the scan nor changes its result.
- R9: tap_o and err_o change only at the edge that raises done_o, and they keep their values until the next result.
- R10: A tap count of 0, or one above MAX_TAPS, gives err_o = 1 and tap_o = 0, with done_o one cycle after the accepting edge.
- R11: An all-zero map gives an error. A map with all 2N bits set gives tap ((2N-1)/2) mod N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Strobe that starts a scan when the block is idle |
| pass_map_i | input | 2*MAX_TAPS | Probe results, captured when start is accepted |
| tap_num_i | input | $clog2(MAX_TAPS+1) | Number of taps N, captured when start is accepted |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| tap_o | output | $clog2(MAX_TAPS) | Chosen tap, 0 on error |
| err_o | output | 1 | No run reached MIN_RUN passes |

## Verification
On every cycle the assertions check the following:
- done is a single-cycle pulse.
- An error result carries tap 0.
- A good tap lies below the captured tap count.
- The outputs stay stable outside the done cycle.
- A start seen during a scan leaves the captured operands unchanged.
- Inside the tracker, the current run never exceeds the bits already scanned, and the best length never shrinks within a scan.

The directed scenarios cover what the assertions cannot decide:
- which run wins a tie
- that a wrapped window and a run still open at the end are both counted
- the exact centre value and the latency
- that map bits above 2N are ignored

// File: rtl/tws_pkg.sv
package tws_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SCAN   = 2'd1,
      ST_FINISH = 2'd2
   } tws_state_e;
endpackage

// File: rtl/tws_run_tracker.sv
// Streams map bits one per cycle and keeps the longest run of ones.
// The fin_* outputs also fold in the run that is still open at the end.
module tws_run_tracker #(
   parameter int IDX_W = 5,
   parameter int LEN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             step_i,
   input  logic             bit_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [LEN_W-1:0] lim_i,
   output logic [LEN_W-1:0] fin_len_o,
   output logic [IDX_W-1:0] fin_start_o,
   output logic [IDX_W-1:0] fin_end_o
);
   logic [LEN_W-1:0] run_q;
   logic [LEN_W-1:0] best_q;
   logic [IDX_W-1:0] bstart_q;
   logic [IDX_W-1:0] bend_q;
   logic [LEN_W-1:0] idx_ext;

   assign idx_ext = LEN_W'(idx_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= '0;
         best_q   <= '0;
         bstart_q <= '0;
         bend_q   <= '0;
      end else if (clear_i) begin
         run_q    <= '0;
         best_q   <= '0;
         bstart_q <= '0;
         bend_q   <= '0;
      end else if (step_i) begin
         if (bit_i) begin
            run_q <= run_q + 1'b1;
         end else begin
            if (run_q > best_q) begin
               best_q   <= run_q;
               bstart_q <= IDX_W'(idx_ext - run_q);
               bend_q   <= IDX_W'(idx_ext - 1'b1);
            end
            run_q <= '0;
         end
      end
   end

   // Close the run that is still open at the end of the scan.
   always_comb begin
      if (run_q > best_q) begin
         fin_len_o   = run_q;
         fin_start_o = IDX_W'(lim_i - run_q);
         fin_end_o   = IDX_W'(lim_i - 1'b1);
      end else begin
         fin_len_o   = best_q;
         fin_start_o = bstart_q;
         fin_end_o   = bend_q;
      end
   end

   // R3: before bit idx is consumed, the open run cannot exceed idx
   p_run_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |-> (run_q <= idx_ext));

   // R4: within a scan the best length never shrinks
   p_best_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i |=> (best_q >= $past(best_q)));
endmodule

// File: rtl/tws_centre_fold.sv
// Midpoint of [start,end], folded into 0..N-1 with one compare-subtract.
// The midpoint never exceeds end <= 2N-1, so one subtraction is enough.
module tws_centre_fold #(
   parameter int IDX_W = 5,
   parameter int CNT_W = 5,
   parameter int TAP_W = 4
) (
   input  logic [IDX_W-1:0] start_i,
   input  logic [IDX_W-1:0] end_i,
   input  logic [CNT_W-1:0] n_i,
   output logic [TAP_W-1:0] tap_o
);
   localparam int SUM_W = IDX_W + 1;
   localparam int CMP_W = (IDX_W > CNT_W) ? IDX_W : CNT_W;

   logic [SUM_W-1:0] sum;
   logic [CMP_W-1:0] half;
   logic [CMP_W-1:0] n_ext;
   logic [CMP_W-1:0] folded;

   always_comb begin
      sum    = SUM_W'(start_i) + SUM_W'(end_i);
      half   = CMP_W'(sum >> 1);
      n_ext  = CMP_W'(n_i);
      folded = (half >= n_ext) ? (half - n_ext) : half;
      tap_o  = TAP_W'(folded);
   end
endmodule

// File: rtl/tap_window_picker.sv
module tap_window_picker #(
   parameter int MAX_TAPS = 16,
   parameter int MIN_RUN  = 3,
   localparam int MAP_W   = 2 * MAX_TAPS,
   localparam int IDX_W   = $clog2(MAP_W),
   localparam int LEN_W   = $clog2(MAP_W + 1),
   localparam int CNT_W   = $clog2(MAX_TAPS + 1),
   localparam int TAP_W   = $clog2(MAX_TAPS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [MAP_W-1:0] pass_map_i,
   input  logic [CNT_W-1:0] tap_num_i,
   output logic             done_o,
   output logic [TAP_W-1:0] tap_o,
   output logic             err_o
);
   import tws_pkg::*;

   if (MAX_TAPS < 2) begin : g_bad_taps
      $error("tap_window_picker: MAX_TAPS must be at least 2");
   end
   if (MIN_RUN < 1 || MIN_RUN > MAP_W) begin : g_bad_min
      $error("tap_window_picker: MIN_RUN must lie in 1..2*MAX_TAPS");
   end

   tws_state_e       state_q;
   logic [MAP_W-1:0] map_q;
   logic [CNT_W-1:0] n_q;
   logic [IDX_W-1:0] idx_q;
   logic [LEN_W-1:0] lim;
   logic             accept;
   logic             n_ok_in;
   logic             n_ok_q;
   logic             last_bit;
   logic [LEN_W-1:0] fin_len;
   logic [IDX_W-1:0] fin_start;
   logic [IDX_W-1:0] fin_end;
   logic [TAP_W-1:0] centre;
   logic             good;

   assign accept   = (state_q == ST_IDLE) && start_i;
   assign n_ok_in  = (tap_num_i != '0) && (tap_num_i <= CNT_W'(MAX_TAPS));
   assign n_ok_q   = (n_q != '0) && (n_q <= CNT_W'(MAX_TAPS));
   assign lim      = LEN_W'(n_q) << 1;
   assign last_bit = (LEN_W'(idx_q) == (lim - 1'b1));
   assign good     = n_ok_q && (fin_len >= LEN_W'(MIN_RUN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         map_q   <= '0;
         n_q     <= '0;
         idx_q   <= '0;
         done_o  <= 1'b0;
         tap_o   <= '0;
         err_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  map_q   <= pass_map_i;
                  n_q     <= tap_num_i;
                  idx_q   <= '0;
                  state_q <= n_ok_in ? ST_SCAN : ST_FINISH;
               end
            end
            ST_SCAN: begin
               idx_q <= idx_q + 1'b1;
               if (last_bit) state_q <= ST_FINISH;
            end
            ST_FINISH: begin
               done_o  <= 1'b1;
               err_o   <= !good;
               tap_o   <= good ? centre : '0;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   tws_run_tracker #(
      .IDX_W (IDX_W),
      .LEN_W (LEN_W)
   ) u_tracker (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (accept),
      .step_i      (state_q == ST_SCAN),
      .bit_i       (map_q[idx_q]),
      .idx_i       (idx_q),
      .lim_i       (lim),
      .fin_len_o   (fin_len),
      .fin_start_o (fin_start),
      .fin_end_o   (fin_end)
   );

   tws_centre_fold #(
      .IDX_W (IDX_W),
      .CNT_W (CNT_W),
      .TAP_W (TAP_W)
   ) u_fold (
      .start_i (fin_start),
      .end_i   (fin_end),
      .n_i     (n_q),
      .tap_o   (centre)
   );

   // R2: done is a single-cycle pulse
   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R6: an error result carries tap 0
   p_err_tap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && err_o) |-> (tap_o == '0));

   // R7: a good tap lies inside 0..N-1
   p_tap_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o) |-> (CNT_W'(tap_o) < n_q));

   // R9: outputs move only with done
   p_hold_outputs_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(tap_o) && $stable(err_o)));

   // R8: a start seen mid-scan does not disturb the captured operands
   p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q != ST_IDLE) && start_i) |=> ($stable(n_q) && $stable(map_q)));
endmodule

// File: tb/tap_window_picker_tb_top.sv
module tap_window_picker_tb_top;
   localparam int MAX_TAPS = 16;
   localparam int MAP_W    = 2 * MAX_TAPS;
   localparam int CNT_W    = $clog2(MAX_TAPS + 1);
   localparam int TAP_W    = $clog2(MAX_TAPS);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [MAP_W-1:0] pass_map_i = '0;
   logic [CNT_W-1:0] tap_num_i = '0;
   logic             done_o;
   logic [TAP_W-1:0] tap_o;
   logic             err_o;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   tap_window_picker #(.MAX_TAPS(MAX_TAPS), .MIN_RUN(3)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .pass_map_i (pass_map_i),
      .tap_num_i  (tap_num_i),
      .done_o     (done_o),
      .tap_o      (tap_o),
      .err_o      (err_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Reference from the requirements: longest strictly-longer run over 2N bits.
   function automatic void model(input logic [MAP_W-1:0] m, input int n,
                                 output bit e, output int t);
      int best = 0, run = 0, bs = 0, be = 0;
      if (n < 1 || n > MAX_TAPS) begin
         e = 1'b1; t = 0; return;
      end
      for (int i = 0; i < 2 * n; i++) begin
         if (m[i]) run++;
         else begin
            if (run > best) begin best = run; bs = i - run; be = i - 1; end
            run = 0;
         end
      end
      if (run > best) begin best = run; bs = 2 * n - run; be = 2 * n - 1; end
      if (best < 3) begin e = 1'b1; t = 0; end
      else begin e = 1'b0; t = ((bs + be) / 2) % n; end
   endfunction

   // Starts a scan and returns the number of rising edges up to done.
   task automatic launch(input logic [MAP_W-1:0] m, input int n, output int edges);
      @(negedge clk);
      pass_map_i = m;
      tap_num_i  = CNT_W'(n);
      start_i    = 1'b1;
      edges = 0;
      for (int k = 0; k < 200; k++) begin
         @(posedge clk);
         edges++;
         @(negedge clk);
         start_i = 1'b0;
         if (done_o) break;
      end
   endtask

   task automatic run_case(input logic [MAP_W-1:0] m, input int n,
                           input string req, input bit exp_e, input int exp_t);
      int edges;
      bit me; int mt;
      logic [TAP_W-1:0] t_s; logic e_s;
      model(m, n, me, mt);
      launch(m, n, edges);
      chk(done_o == 1'b1, {req, " done"}, int'(done_o), 1);
      chk(edges == 2 * ((n < 1 || n > MAX_TAPS) ? 0 : n) + 2, "R2 latency", edges,
          2 * ((n < 1 || n > MAX_TAPS) ? 0 : n) + 2);
      chk(err_o == exp_e, {req, " err"}, int'(err_o), int'(exp_e));
      chk(int'(tap_o) == exp_t, {req, " tap"}, int'(tap_o), exp_t);
      chk(me == exp_e && mt == exp_t, {req, " model"}, mt, exp_t);
      t_s = tap_o; e_s = err_o;
      @(negedge clk);
      chk(done_o == 1'b0, "R2 one-cycle done", int'(done_o), 0);
      repeat (3) @(negedge clk);
      chk(tap_o == t_s && err_o == e_s, "R9 hold", int'(tap_o), int'(t_s));
   endtask

   task automatic t_reset();
      chk(done_o == 1'b0 && err_o == 1'b0 && tap_o == '0, "R1 reset",
          int'({done_o, err_o, tap_o}), 0);
   endtask

   task automatic t_all_zero();  run_case('0, 8, "R11 all zero", 1'b1, 0); endtask
   task automatic t_all_ones();  run_case('1, 16, "R11 all ones", 1'b0, 15); endtask
   task automatic t_all_ones_5(); run_case(32'h0000_03FF, 5, "R11 all ones N5", 1'b0, 4); endtask
   // R3: passes at taps 6,7,0,1 of N=8 -> run 6..9 -> tap 7
   task automatic t_wrap();      run_case(32'h0000_C3C3, 8, "R3 wrap", 1'b0, 7); endtask
   // R3: upper bits beyond 2N are ignored
   task automatic t_upper();     run_case(32'hFFFF_FF0E, 4, "R3 upper bits", 1'b0, 2); endtask
   // R4: equal runs at 1..3 and 10..12 -> earlier -> tap 2
   task automatic t_tie();       run_case(32'h0000_1C0E, 8, "R4 tie", 1'b0, 2); endtask
   // R5: run 12..15 open at end beats 2..4 -> 13 mod 8 = 5
   task automatic t_open();      run_case(32'h0000_F01C, 8, "R5 open run", 1'b0, 5); endtask
   task automatic t_short();     run_case(32'h0000_0060, 4, "R6 short run", 1'b1, 0); endtask
   task automatic t_exact();     run_case(32'h0000_000E, 4, "R7 minimum run", 1'b0, 2); endtask
   // R7: run 3..9 of N=6 -> 6 mod 6 = 0
   task automatic t_centre();    run_case(32'h0000_03F8, 6, "R7 fold", 1'b0, 0); endtask
   task automatic t_n_zero();    run_case('1, 0, "R10 N zero", 1'b1, 0); endtask
   task automatic t_n_big();     run_case('1, 17, "R10 N too big", 1'b1, 0); endtask

   task automatic t_busy();
      int edges = 0;
      @(negedge clk);
      pass_map_i = 32'h0000_C3C3; tap_num_i = 5'd8; start_i = 1'b1;
      for (int k = 0; k < 200; k++) begin
         @(posedge clk);
         edges++;
         @(negedge clk);
         if (edges == 3) begin
            start_i = 1'b1; pass_map_i = '0; tap_num_i = 5'd2;
         end else start_i = 1'b0;
         if (done_o) break;
      end
      chk(edges == 18, "R8 latency kept", edges, 18);
      chk(err_o == 1'b0 && tap_o == 4'd7, "R8 result kept", int'(tap_o), 7);
      start_i = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_all_zero();
      t_all_ones();
      t_all_ones_5();
      t_wrap();
      t_upper();
      t_tie();
      t_open();
      t_short();
      t_exact();
      t_centre();
      t_n_zero();
      t_n_big();
      t_busy();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule